// File: doc/BRIEF.md
# Accumulator Machine Execute Unit

This block carries out the memory-reference and load-immediate instructions of a 16-bit accumulator machine with a one-bit link. A sequencer gives it an opcode that is already decoded, an indirect flag, an address field and the program counter of the next instruction. The unit resolves the effective address, performing one level of indirection when the flag is set. It reads or writes a synchronous memory port and updates the accumulator, the link and the program counter. It then signals completion and reports how many machine cycles the instruction accounts for.

The memory port is a plain request/response interface. A read issued in one cycle returns its data in the next cycle. A write takes effect at the clock edge where it is issued. The unit holds the accumulator and the link across instructions. The program counter passes through it: it is taken from `pc_in` when an instruction starts and is presented on `pc_out` when the instruction completes.

Top module: `acc_exec_unit`

## Requirements
- R1: After reset, `ac` = 0, `lnk` = 0, `pc_out` = 0, `busy` = 0 and `done` = 0.
- R2: `start` is taken only while `busy` is low. After an accepted start, `busy` is high from the next cycle up to and including the single cycle in which `done` is high, and `ac`/`lnk` do not change while the unit is idle and not started.
- R3: Opcode 0 (load immediate) sets `ac` to the address field zero-extended to 16 bits, or to the 16-bit complement of that value when the indirect flag is set. It does not touch memory and reports `cycles` = 1.
- R4: Opcodes 1 to 12 are memory references. Their effective address is the address field when direct, and the low 12 bits of the word read at the address field when indirect. They report `cycles` = 2 when direct and 3 when indirect. `pc_out` equals `pc_in` unless a requirement below changes it.
- R5: Opcode 1 (jump) sets `pc_out` to the effective address.
- R6: Opcode 2 (deposit) writes `ac` to the effective address and leaves `ac` unchanged. Only opcodes 2, 3, 4 and 5 write memory.
- R7: Opcode 3 (exchange) writes the old `ac` to the effective address and loads `ac` with the old memory word.
- R8: Opcode 4 (increment and skip) writes the memory word plus 1, modulo 2^16, back to the effective address. `pc_out` is `pc_in`+1 (mod 2^12) when the new value is zero.
- R9: Opcode 5 (subroutine call) writes `pc_in`, zero-extended, to the effective address, and sets `pc_out` to the effective address + 1 (mod 2^12).
- R10: Opcodes 6, 7, 8 and 9 set `ac` to `ac` AND, OR or XOR the operand, or to the operand itself, in that order of codes.
- R11: Opcode 10 (add) forms the 17-bit sum of `ac` and the operand, complements `lnk` when bit 16 of the sum is 1, and sets `ac` to the low 16 bits.
- R12: Opcode 11 (subtract) adds the 16-bit two's complement of the operand to `ac` in the same 17-bit way, complementing `lnk` when bit 16 is 1.
- R13: Opcode 12 (skip if equal) sets `pc_out` to `pc_in`+1 (mod 2^12) when `ac` equals the operand.
- R14: Opcodes 13 to 15 complete with `cycles` = 1. They make no memory access and leave `ac`, `lnk` and `pc_out` (= `pc_in`) unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an instruction (taken when idle) |
| op | input | 4 | Decoded opcode |
| ind | input | 1 | Indirect flag (complement select for opcode 0) |
| addr | input | 12 | Address field |
| pc_in | input | 12 | Program counter of the following instruction |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| cycles | output | 2 | Machine cycles used, valid with done |
| ac | output | 16 | Accumulator |
| lnk | output | 1 | Link bit |
| pc_out | output | 12 | Resulting program counter, valid with done |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 12 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after a read request |

## Verification
For exchange and increment-and-skip, the unit consumes the returning read data in the same cycle in which it issues the write-back to the same word. For increment-and-skip, the skip decision is also taken in that cycle. The bench provokes this with indirect exchanges through a pointer that points at itself, with increments that wrap a word from 0xFFFF to zero, and with many random read-modify-write instructions on random addresses. The results are judged against a reference model in the bench that tracks `ac`, `lnk`, `pc_out` and a full memory shadow. The shadow is compared word by word with the memory model at the end of the run.

// File: rtl/acc_exec_pkg.sv
package acc_exec_pkg;

  localparam int OPW = 4;
  localparam int CYW = 2;

  typedef enum logic [OPW-1:0] {
    OP_LDI = 4'd0,
    OP_JMP = 4'd1,
    OP_DEP = 4'd2,
    OP_XCH = 4'd3,
    OP_ISZ = 4'd4,
    OP_JSR = 4'd5,
    OP_AND = 4'd6,
    OP_IOR = 4'd7,
    OP_XOR = 4'd8,
    OP_LDA = 4'd9,
    OP_ADD = 4'd10,
    OP_SUB = 4'd11,
    OP_SKE = 4'd12
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PTR,
    ST_PTRW,
    ST_EA,
    ST_DATW,
    ST_FIN
  } st_e;

  function automatic logic op_is_mem(input logic [OPW-1:0] o);
    return (o >= OP_JMP) && (o <= OP_SKE);
  endfunction

endpackage

// File: rtl/acc_exec_rst_sync.sv
module acc_exec_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/acc_exec_alu.sv
module acc_exec_alu
  import acc_exec_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic [OPW-1:0] x_op,
  input  logic           x_ind,
  input  logic [AW-1:0]  x_addr,
  input  logic [DW-1:0]  ac,
  input  logic           lnk,
  input  logic [DW-1:0]  opnd,
  output logic [DW-1:0]  ac_nxt,
  output logic           lnk_nxt,
  output logic           skip,
  output logic [DW-1:0]  inc_val
);

  logic [DW-1:0] imm_word;
  logic [DW-1:0] neg_opnd;
  logic [DW:0]   sum;

  always_comb begin
    imm_word = DW'(x_addr);
    neg_opnd = ~opnd + DW'(1);
    inc_val  = opnd + DW'(1);
    if (x_op == OP_SUB) begin
      sum = {1'b0, ac} + {1'b0, neg_opnd};
    end else begin
      sum = {1'b0, ac} + {1'b0, opnd};
    end
  end

  always_comb begin
    ac_nxt  = ac;
    lnk_nxt = lnk;
    skip    = 1'b0;
    case (x_op)
      OP_LDI: ac_nxt = x_ind ? ~imm_word : imm_word;
      OP_XCH: ac_nxt = opnd;
      OP_ISZ: skip   = (inc_val == '0);
      OP_AND: ac_nxt = ac & opnd;
      OP_IOR: ac_nxt = ac | opnd;
      OP_XOR: ac_nxt = ac ^ opnd;
      OP_LDA: ac_nxt = opnd;
      OP_ADD, OP_SUB: begin
        ac_nxt  = sum[DW-1:0];
        lnk_nxt = lnk ^ sum[DW];
      end
      OP_SKE: skip = (ac == opnd);
      default: ;
    endcase
  end

endmodule

// File: rtl/acc_exec_arch.sv
module acc_exec_arch #(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ac_we,
  input  logic [DW-1:0] ac_in,
  input  logic          lnk_we,
  input  logic          lnk_in,
  input  logic          pc_we,
  input  logic [AW-1:0] pc_in,
  output logic [DW-1:0] ac_q,
  output logic          lnk_q,
  output logic [AW-1:0] pc_q
);

  logic [DW-1:0] ac_d;
  logic          lnk_d;
  logic [AW-1:0] pc_d;

  always_comb begin
    ac_d  = ac_q;
    lnk_d = lnk_q;
    pc_d  = pc_q;
    if (ac_we)  ac_d  = ac_in;
    if (lnk_we) lnk_d = lnk_in;
    if (pc_we)  pc_d  = pc_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_q  <= '0;
      lnk_q <= 1'b0;
      pc_q  <= '0;
    end else begin
      ac_q  <= ac_d;
      lnk_q <= lnk_d;
      pc_q  <= pc_d;
    end
  end

endmodule

// File: rtl/acc_exec_ctrl.sv
module acc_exec_ctrl
  import acc_exec_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [OPW-1:0] op,
  input  logic           ind,
  input  logic [AW-1:0]  addr,
  input  logic [AW-1:0]  pc_in,
  input  logic [DW-1:0]  ac,
  input  logic [AW-1:0]  pc,
  input  logic [AW-1:0]  ptr_word,
  input  logic [DW-1:0]  inc_val,
  input  logic           skip,
  output logic           busy,
  output logic           done,
  output logic [CYW-1:0] cycles,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  output logic [OPW-1:0] x_op,
  output logic           x_ind,
  output logic [AW-1:0]  x_addr,
  output logic           ac_we,
  output logic           lnk_we,
  output logic           pc_we,
  output logic [AW-1:0]  pc_d
);

  st_e            st_q, st_d;
  logic [OPW-1:0] op_q;
  logic           ind_q;
  logic [AW-1:0]  ea_q, ea_d;
  logic           ld_en, ea_en;

  always_comb begin
    st_d      = st_q;
    ld_en     = 1'b0;
    ea_en     = 1'b0;
    ea_d      = addr;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = ea_q;
    mem_wdata = ac;
    ac_we     = 1'b0;
    lnk_we    = 1'b0;
    pc_we     = 1'b0;
    pc_d      = pc;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          ld_en = 1'b1;
          ea_en = 1'b1;
          pc_we = 1'b1;
          pc_d  = pc_in;
          if (op == OP_LDI) begin
            ac_we = 1'b1;
            st_d  = ST_FIN;
          end else if (!op_is_mem(op)) begin
            st_d = ST_FIN;
          end else if (ind) begin
            st_d = ST_PTR;
          end else begin
            st_d = ST_EA;
          end
        end
      end
      ST_PTR: begin
        mem_req = 1'b1;
        st_d    = ST_PTRW;
      end
      ST_PTRW: begin
        ea_en = 1'b1;
        ea_d  = ptr_word;
        st_d  = ST_EA;
      end
      ST_EA: begin
        mem_req = 1'b1;
        st_d    = ST_DATW;
        case (op_q)
          OP_JMP: begin
            mem_req = 1'b0;
            pc_we   = 1'b1;
            pc_d    = ea_q;
            st_d    = ST_FIN;
          end
          OP_DEP: begin
            mem_we    = 1'b1;
            mem_wdata = ac;
            st_d      = ST_FIN;
          end
          OP_JSR: begin
            mem_we    = 1'b1;
            mem_wdata = DW'(pc);
            pc_we     = 1'b1;
            pc_d      = ea_q + AW'(1);
            st_d      = ST_FIN;
          end
          default: ;
        endcase
      end
      ST_DATW: begin
        st_d = ST_FIN;
        case (op_q)
          OP_XCH: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_wdata = ac;
            ac_we     = 1'b1;
          end
          OP_ISZ: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_wdata = inc_val;
            pc_we     = skip;
            pc_d      = pc + AW'(1);
          end
          OP_SKE: begin
            pc_we = skip;
            pc_d  = pc + AW'(1);
          end
          OP_ADD, OP_SUB: begin
            ac_we  = 1'b1;
            lnk_we = 1'b1;
          end
          OP_AND, OP_IOR, OP_XOR, OP_LDA: ac_we = 1'b1;
          default: ;
        endcase
      end
      ST_FIN: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      op_q  <= '0;
      ind_q <= 1'b0;
      ea_q  <= '0;
    end else begin
      st_q <= st_d;
      if (ld_en) begin
        op_q  <= op;
        ind_q <= ind;
      end
      if (ea_en) begin
        ea_q <= ea_d;
      end
    end
  end

  assign busy   = (st_q != ST_IDLE);
  assign done   = (st_q == ST_FIN);
  assign cycles = op_is_mem(op_q) ? (ind_q ? CYW'(3) : CYW'(2)) : CYW'(1);
  assign x_op   = (st_q == ST_IDLE) ? op   : op_q;
  assign x_ind  = (st_q == ST_IDLE) ? ind  : ind_q;
  assign x_addr = (st_q == ST_IDLE) ? addr : ea_q;

  // R2: completion is a single-cycle pulse
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2: an accepted start keeps the unit busy until done
  a_r2_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R3, R14: no memory traffic for non-memory opcodes, finished next cycle
  a_r3_imm_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !op_is_mem(op)) |=> (done && !mem_req));

  // R4: indirect starts by reading the pointer at the address field
  a_r4_ptr_read: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && ind && op_is_mem(op))
      |=> (mem_req && !mem_we && mem_addr == $past(addr)));

  // R4: direct access goes straight to the address field
  a_r4_direct_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !ind && op_is_mem(op) && op != OP_JMP)
      |=> (mem_req && mem_addr == $past(addr)));

  // R6: only deposit, exchange, increment and call write memory
  a_r6_we_ops: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we)
      |-> (op_q == OP_DEP || op_q == OP_XCH || op_q == OP_ISZ || op_q == OP_JSR));

endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
  import acc_exec_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [OPW-1:0] op,
  input  logic           ind,
  input  logic [AW-1:0]  addr,
  input  logic [AW-1:0]  pc_in,
  output logic           busy,
  output logic           done,
  output logic [CYW-1:0] cycles,
  output logic [DW-1:0]  ac,
  output logic           lnk,
  output logic [AW-1:0]  pc_out,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata
);

  logic           rst_sync_n;
  logic [OPW-1:0] x_op;
  logic           x_ind;
  logic [AW-1:0]  x_addr;
  logic [DW-1:0]  ac_nxt;
  logic           lnk_nxt;
  logic           skip;
  logic [DW-1:0]  inc_val;
  logic           ac_we, lnk_we, pc_we;
  logic [AW-1:0]  pc_d;

  acc_exec_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  acc_exec_ctrl #(.DW(DW), .AW(AW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (start),
    .op        (op),
    .ind       (ind),
    .addr      (addr),
    .pc_in     (pc_in),
    .ac        (ac),
    .pc        (pc_out),
    .ptr_word  (mem_rdata[AW-1:0]),
    .inc_val   (inc_val),
    .skip      (skip),
    .busy      (busy),
    .done      (done),
    .cycles    (cycles),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .x_op      (x_op),
    .x_ind     (x_ind),
    .x_addr    (x_addr),
    .ac_we     (ac_we),
    .lnk_we    (lnk_we),
    .pc_we     (pc_we),
    .pc_d      (pc_d)
  );

  acc_exec_alu #(.DW(DW), .AW(AW)) u_alu (
    .x_op    (x_op),
    .x_ind   (x_ind),
    .x_addr  (x_addr),
    .ac      (ac),
    .lnk     (lnk),
    .opnd    (mem_rdata),
    .ac_nxt  (ac_nxt),
    .lnk_nxt (lnk_nxt),
    .skip    (skip),
    .inc_val (inc_val)
  );

  acc_exec_arch #(.DW(DW), .AW(AW)) u_arch (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .ac_we  (ac_we),
    .ac_in  (ac_nxt),
    .lnk_we (lnk_we),
    .lnk_in (lnk_nxt),
    .pc_we  (pc_we),
    .pc_in  (pc_d),
    .ac_q   (ac),
    .lnk_q  (lnk),
    .pc_q   (pc_out)
  );

  // R2: architectural state holds while idle and not started
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy && !start) |=> ($stable(ac) && $stable(lnk)));

endmodule

// File: tb/acc_exec_unit_test.sv
`timescale 1ns/100ps
module acc_exec_unit_test;

  localparam int DW   = 16;
  localparam int AW   = 12;
  localparam int MEMW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [3:0]    op = '0;
  logic          ind = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [AW-1:0] pc_in = '0;
  logic          busy, done, lnk, mem_req, mem_we;
  logic [1:0]    cycles;
  logic [DW-1:0] ac, mem_wdata;
  logic [DW-1:0] mem_rdata;
  logic [AW-1:0] pc_out, mem_addr;

  logic [DW-1:0] mem [0:MEMW-1];
  logic [DW-1:0] ref_mem [0:MEMW-1];
  logic          fill = 1'b1;
  logic [DW-1:0] r_ac = '0;
  logic          r_lnk = 1'b0;
  int            checks = 0;
  int            errs = 0;
  bit            finished = 1'b0;

  always #2.5 clk = ~clk;

  acc_exec_unit #(.DW(DW), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .ind(ind),
    .addr(addr), .pc_in(pc_in), .busy(busy), .done(done),
    .cycles(cycles), .ac(ac), .lnk(lnk), .pc_out(pc_out),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [DW-1:0] seed_word(input int a);
    return DW'((a * 40503) ^ 32'h3C5A);
  endfunction

  always @(posedge clk) begin
    if (fill) begin
      for (int k = 0; k < MEMW; k++) mem[k] <= seed_word(k);
      mem_rdata <= '0;
    end else if (mem_req) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr];
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string op_tag(input logic [3:0] o);
    case (o)
      4'd0: return "R3";
      4'd1: return "R5";
      4'd2: return "R6";
      4'd3: return "R7";
      4'd4: return "R8";
      4'd5: return "R9";
      4'd6, 4'd7, 4'd8, 4'd9: return "R10";
      4'd10: return "R11";
      4'd11: return "R12";
      4'd12: return "R13";
      default: return "R14";
    endcase
  endfunction

  task automatic issue(input logic [3:0] o, input logic i,
                       input logic [AW-1:0] a, input logic [AW-1:0] p);
    logic [AW-1:0] ea;
    logic [DW-1:0] m, e_ac, neg;
    logic [DW:0]   s;
    logic          e_l, is_mem, wr;
    logic [AW-1:0] e_pc;
    logic [1:0]    e_cyc;
    string         tag;
    int            n;
    tag    = op_tag(o);
    is_mem = (o >= 4'd1) && (o <= 4'd12);
    ea     = i ? ref_mem[a][AW-1:0] : a;
    m      = ref_mem[ea];
    e_ac   = r_ac;
    e_l    = r_lnk;
    e_pc   = p;
    wr     = 1'b0;
    e_cyc  = is_mem ? (i ? 2'd3 : 2'd2) : 2'd1;
    case (o)
      4'd0: e_ac = i ? ~DW'(a) : DW'(a);
      4'd1: e_pc = ea;
      4'd2: begin ref_mem[ea] = r_ac; wr = 1'b1; end
      4'd3: begin e_ac = m; ref_mem[ea] = r_ac; wr = 1'b1; end
      4'd4: begin
        ref_mem[ea] = m + 16'd1; wr = 1'b1;
        if (ref_mem[ea] == 16'd0) e_pc = p + 12'd1;
      end
      4'd5: begin ref_mem[ea] = DW'(p); wr = 1'b1; e_pc = ea + 12'd1; end
      4'd6: e_ac = r_ac & m;
      4'd7: e_ac = r_ac | m;
      4'd8: e_ac = r_ac ^ m;
      4'd9: e_ac = m;
      4'd10: begin
        s = {1'b0, r_ac} + {1'b0, m};
        e_ac = s[DW-1:0];
        if (s[DW]) e_l = ~e_l;
      end
      4'd11: begin
        neg = ~m + 16'd1;
        s = {1'b0, r_ac} + {1'b0, neg};
        e_ac = s[DW-1:0];
        if (s[DW]) e_l = ~e_l;
      end
      4'd12: if (r_ac == m) e_pc = p + 12'd1;
      default: ;
    endcase

    @(negedge clk);
    start = 1'b1; op = o; ind = i; addr = a; pc_in = p;
    @(negedge clk);
    start = 1'b0;
    op = 4'($urandom); addr = AW'($urandom); pc_in = AW'($urandom); ind = 1'($urandom);
    chk("R2", "busy after start", 32'(busy), 32'd1);
    n = 0;
    while (!done && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk("R2", "done reached", 32'(done), 32'd1);
    chk(is_mem ? "R4" : tag, "cycles", 32'(cycles), 32'(e_cyc));
    chk(tag, "ac", 32'(ac), 32'(e_ac));
    chk(tag, "lnk", 32'(lnk), 32'(e_l));
    chk(tag, "pc_out", 32'(pc_out), 32'(e_pc));
    if (wr) chk(tag, "memory word", 32'(mem[ea]), 32'(ref_mem[ea]));
    r_ac  = e_ac;
    r_lnk = e_l;
  endtask

  initial begin
    void'($urandom(32'h5EED1234));
    for (int k = 0; k < MEMW; k++) ref_mem[k] = seed_word(k);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    fill = 1'b0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1", "ac", 32'(ac), 32'd0);
    chk("R1", "lnk", 32'(lnk), 32'd0);
    chk("R1", "pc_out", 32'(pc_out), 32'd0);
    chk("R1", "busy", 32'(busy), 32'd0);
    chk("R1", "done", 32'(done), 32'd0);

    issue(4'd0, 1'b1, 12'h000, 12'h010);   // R3 complement -> FFFF
    issue(4'd0, 1'b0, 12'hABC, 12'h011);   // R3 plain
    issue(4'd0, 1'b1, 12'h000, 12'h012);
    issue(4'd2, 1'b0, 12'h100, 12'h013);   // R6 deposit FFFF
    issue(4'd4, 1'b0, 12'h100, 12'h200);   // R8 wraps to zero, skip
    issue(4'd4, 1'b0, 12'h100, 12'hFFF);   // R8 no skip
    issue(4'd0, 1'b1, 12'h000, 12'h020);   // ac = FFFF
    issue(4'd10, 1'b0, 12'h100, 12'h021);  // R11 carry toggles link
    issue(4'd11, 1'b0, 12'h100, 12'h022);  // R12 0-1 no carry
    issue(4'd11, 1'b0, 12'h100, 12'h023);  // R12 FFFF-1 carry
    issue(4'd0, 1'b0, 12'h000, 12'h024);
    issue(4'd2, 1'b0, 12'h101, 12'h025);   // mem[101] = 0
    issue(4'd0, 1'b0, 12'h345, 12'h026);
    issue(4'd11, 1'b0, 12'h101, 12'h027);  // R12 subtract zero
    issue(4'd0, 1'b1, 12'hEDC, 12'h028);   // ac = F123
    issue(4'd2, 1'b0, 12'h300, 12'h029);   // pointer with high bits
    issue(4'd9, 1'b1, 12'h300, 12'h02A);   // R4 masked indirect load
    issue(4'd5, 1'b0, 12'hFFF, 12'h456);   // R9 call wraps pc
    issue(4'd1, 1'b1, 12'h300, 12'h02B);   // R5 indirect jump
    issue(4'd9, 1'b0, 12'h100, 12'h02C);
    issue(4'd12, 1'b0, 12'h100, 12'h02D);  // R13 equal skip
    issue(4'd12, 1'b0, 12'h101, 12'h02E);  // R13 no skip
    issue(4'd13, 1'b1, 12'h100, 12'h02F);  // R14
    issue(4'd15, 1'b0, 12'h100, 12'h030);  // R14
    issue(4'd0, 1'b0, 12'h050, 12'h031);
    issue(4'd2, 1'b0, 12'h050, 12'h032);   // self pointer
    issue(4'd0, 1'b0, 12'h777, 12'h033);
    issue(4'd3, 1'b1, 12'h050, 12'h034);   // R7 indirect exchange on self
    issue(4'd6, 1'b0, 12'h050, 12'h035);   // R10
    issue(4'd7, 1'b1, 12'h300, 12'h036);
    issue(4'd8, 1'b0, 12'h100, 12'h037);

    for (int t = 0; t < 400; t++) begin
      issue(4'($urandom), 1'($urandom), AW'($urandom), AW'($urandom));
    end

    begin
      int bad;
      bad = 0;
      for (int k = 0; k < MEMW; k++) if (mem[k] !== ref_mem[k]) bad++;
      chk("R6", "memory image mismatches", 32'(bad), 32'd0);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errs++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule